// File: doc/BRIEF.md
# Pulse-Width Byte Modulator

This block turns one byte into a timed sequence of low and high intervals on a single modulation line. Each bit gets a fixed period. The period starts with the line low, which stops modulation, and ends with the line high, which modulates the antenna. The bit value is carried only by where the rising edge falls inside that period. A 1 uses equal low and high halves. A 0 uses a short low interval and a long high interval. Bits leave least significant first. All timing advances only on an external one-microsecond tick enable, so the system clock frequency does not affect the waveform.

The byte enters on a valid/ready handshake. The block is ready only while idle. A byte is taken in the cycle where `in_valid` and `in_ready` are both high. While a byte is in flight, `in_ready` stays low and the source must hold or drop its request; any `in_valid` seen then is not taken, and `in_data` is not looked at. After the last interval, `done` pulses once and the line stays high, with modulation on, until the next byte.

Top module: `pwbm_top`

## Requirements
- R1: Out of reset and whenever idle, `mod_out` is 1, `busy` is 0, `done` is 0 and `in_ready` is 1.
- R2: A byte is taken at a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle `busy` is 1 and `mod_out` is 0. Bit 0 is sent first and bit 7 last.
- R3: A bit of value 1 holds `mod_out` at 0 for ONE_LOW_US ticks, then at 1 for ONE_HIGH_US ticks (defaults 1000 and 1000).
- R4: A bit of value 0 holds `mod_out` at 0 for ZERO_LOW_US ticks, then at 1 for ZERO_HIGH_US ticks (defaults 300 and 1700).
- R5: Every bit spans the same number of ticks, ONE_LOW_US + ONE_HIGH_US, whatever its value.
- R6: While `busy` is 1, `in_ready` is 0. A request and any change of `in_data` during that time have no effect on the waveform, and no second byte starts from them.
- R7: One cycle after the tick that ends the high interval of the last bit, `done` is 1 for exactly one cycle, `busy` is 0 in that same cycle, and `mod_out` stays 1.
- R8: A cycle without `tick_us` changes neither `mod_out` nor `busy`, and no interval count advances.
- R9: A new byte can be taken at the edge that ends the `done` cycle, so bytes can follow each other with one idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-microsecond tick enable, one cycle wide |
| in_valid | input | 1 | Byte offered |
| in_ready | output | 1 | Block idle and able to take a byte |
| in_data | input | DATA_W | Byte to send, bit 0 first |
| mod_out | output | 1 | Modulation line: 0 stops modulation, 1 modulates |
| busy | output | 1 | A byte is being sent |
| done | output | 1 | One-cycle pulse after the last interval |

## Verification
The bench builds the block with interval lengths of 3/3 ticks for a 1 and 1/5 ticks for a 0. This keeps the same rule of equal bit periods and makes every byte only a few dozen ticks long. The 1-tick low interval reaches the shortest legal interval, where the counter expires on the first tick it sees. With these short lengths, all-ones, all-zeros and mixed bytes can be driven under three tick patterns: every cycle, every third cycle and pseudo-random. The bench also covers stalls with no tick, requests while busy and back-to-back bytes.

// File: rtl/pwbm_pkg.sv
package pwbm_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } pwbm_phase_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/pwbm_interval_timer.sv
module pwbm_interval_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clear,
  input  logic             tick,
  input  logic [CNT_W-1:0] len,
  output logic             expire
);

  logic [CNT_W-1:0] cnt_q;

  // an interval of len ticks ends on the tick that finds cnt_q at len-1
  assign expire = run && tick && (cnt_q == len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear || expire) begin
      cnt_q <= '0;
    end else if (run && tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/pwbm_bit_shifter.sv
module pwbm_bit_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  logic              shift,
  output logic              cur_bit,
  output logic              last_bit
);

  localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  logic [DATA_W-1:0] sr_q;
  logic [IDX_W-1:0]  idx_q;

  assign cur_bit  = sr_q[0];
  assign last_bit = (idx_q == IDX_W'(DATA_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q  <= '0;
      idx_q <= '0;
    end else if (load) begin
      sr_q  <= data;
      idx_q <= '0;
    end else if (shift) begin
      sr_q  <= sr_q >> 1;
      idx_q <= idx_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/pwbm_sequencer.sv
module pwbm_sequencer
  import pwbm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accept,
  input  logic        expire,
  input  logic        last_bit,
  output pwbm_phase_e phase,
  output logic        shift,
  output logic        mod_q,
  output logic        done_q
);

  pwbm_phase_e phase_q;

  assign phase = phase_q;
  assign shift = (phase_q == PH_HIGH) && expire && !last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      mod_q   <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (phase_q)
        PH_IDLE: begin
          if (accept) begin
            phase_q <= PH_LOW;
            mod_q   <= 1'b0;
          end
        end
        PH_LOW: begin
          if (expire) begin
            phase_q <= PH_HIGH;
            mod_q   <= 1'b1;
          end
        end
        PH_HIGH: begin
          if (expire) begin
            if (last_bit) begin
              phase_q <= PH_IDLE;
              done_q  <= 1'b1;
            end else begin
              phase_q <= PH_LOW;
              mod_q   <= 1'b0;
            end
          end
        end
        default: begin
          phase_q <= PH_IDLE;
          mod_q   <= 1'b1;
        end
      endcase
    end
  end

endmodule

// File: rtl/pwbm_top.sv
module pwbm_top
  import pwbm_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int ONE_LOW_US   = 1000,
  parameter int ONE_HIGH_US  = 1000,
  parameter int ZERO_LOW_US  = 300,
  parameter int ZERO_HIGH_US = 1700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_us,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              mod_out,
  output logic              busy,
  output logic              done
);

  localparam int MAX_LEN = max_of4(ONE_LOW_US, ONE_HIGH_US, ZERO_LOW_US, ZERO_HIGH_US);
  localparam int CNT_W   = $clog2(MAX_LEN + 1);

  pwbm_phase_e      phase;
  logic             accept;
  logic             expire;
  logic             shift;
  logic             cur_bit;
  logic             last_bit;
  logic [CNT_W-1:0] len;

  assign busy     = (phase != PH_IDLE);
  assign in_ready = !busy;
  assign accept   = in_valid && in_ready;

  always_comb begin
    if (phase == PH_LOW) begin
      len = cur_bit ? CNT_W'(ONE_LOW_US) : CNT_W'(ZERO_LOW_US);
    end else begin
      len = cur_bit ? CNT_W'(ONE_HIGH_US) : CNT_W'(ZERO_HIGH_US);
    end
  end

  pwbm_interval_timer #(.CNT_W(CNT_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (busy),
    .clear  (accept),
    .tick   (tick_us),
    .len    (len),
    .expire (expire)
  );

  pwbm_bit_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .data     (in_data),
    .shift    (shift),
    .cur_bit  (cur_bit),
    .last_bit (last_bit)
  );

  pwbm_sequencer u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .expire   (expire),
    .last_bit (last_bit),
    .phase    (phase),
    .shift    (shift),
    .mod_q    (mod_out),
    .done_q   (done)
  );

endmodule

// File: rtl/pwbm_checker.sv
module pwbm_checker #(
  parameter int PERIOD = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic tick_us,
  input logic in_valid,
  input logic in_ready,
  input logic mod_out,
  input logic busy,
  input logic done
);

  logic        mod_d;
  logic        busy_d;
  int unsigned tcnt;
  logic        fell_in_byte;

  assign fell_in_byte = busy && busy_d && mod_d && !mod_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_d  <= 1'b1;
      busy_d <= 1'b0;
      tcnt   <= 0;
    end else begin
      mod_d  <= mod_out;
      busy_d <= busy;
      if (in_valid && in_ready) begin
        tcnt <= 0;
      end else if (fell_in_byte || done) begin
        tcnt <= 32'(tick_us && busy);
      end else begin
        tcnt <= tcnt + 32'(tick_us && busy);
      end
    end
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> mod_out);

  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (busy && !mod_out));

  assert_bit_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fell_in_byte |-> (tcnt == PERIOD));

  assert_last_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (tcnt == PERIOD));

  assert_busy_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && in_valid && !done) |=> (busy || done));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && mod_out));

  assert_end_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  assert_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick_us) |=> (busy && $stable(mod_out)));

endmodule

bind pwbm_top pwbm_checker #(.PERIOD(ONE_LOW_US + ONE_HIGH_US)) u_pwbm_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick_us  (tick_us),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .mod_out  (mod_out),
  .busy     (busy),
  .done     (done)
);

// File: tb/test_pwbm_top.sv
`timescale 1ns/1ps
module test_pwbm_top;

  localparam int DW  = 8;
  localparam int OL  = 3;
  localparam int OH  = 3;
  localparam int ZL  = 1;
  localparam int ZH  = 5;
  localparam int PER = OL + OH;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick_us = 1'b0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready;
  logic          mod_out;
  logic          busy;
  logic          done;

  always #2.5 clk = ~clk;

  pwbm_top #(
    .DATA_W(DW), .ONE_LOW_US(OL), .ONE_HIGH_US(OH),
    .ZERO_LOW_US(ZL), .ZERO_HIGH_US(ZH)
  ) i_pwbm_top (
    .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .mod_out(mod_out),
    .busy(busy), .done(done)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // tick pattern: 0 every cycle, 1 every third cycle, 2 pseudo-random, 3 none
  int          tick_mode = 0;
  logic [6:0]  lfsr = 7'h5A;
  int unsigned tick_phase = 0;
  always @(posedge clk) begin
    lfsr       <= {lfsr[5:0], lfsr[6] ^ lfsr[5]};
    tick_phase <= tick_phase + 1;
    case (tick_mode)
      0:       tick_us <= 1'b1;
      1:       tick_us <= (tick_phase % 3 == 0);
      2:       tick_us <= lfsr[0];
      default: tick_us <= 1'b0;
    endcase
  end

  // reference model: queue of timed segments
  int seg_lvl[$];
  int seg_len[$];
  int seg_bit[$];
  bit m_done = 1'b0;
  int b_ticks = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      seg_lvl.delete(); seg_len.delete(); seg_bit.delete();
      m_done  = 1'b0;
      b_ticks = 0;
    end else begin
      m_done = 1'b0;
      if (seg_len.size() != 0) begin
        if (tick_us) begin
          b_ticks++;
          seg_len[0] = seg_len[0] - 1;
          if (seg_len[0] == 0) begin
            void'(seg_lvl.pop_front());
            void'(seg_len.pop_front());
            void'(seg_bit.pop_front());
            if (seg_len.size() == 0) m_done = 1'b1;
          end
        end
      end else if (in_valid) begin
        b_ticks = 0;
        for (int i = 0; i < DW; i++) begin
          int b;
          b = int'(in_data[i]);
          seg_lvl.push_back(0); seg_len.push_back(b ? OL : ZL); seg_bit.push_back(b);
          seg_lvl.push_back(1); seg_len.push_back(b ? OH : ZH); seg_bit.push_back(b);
        end
      end
    end
  end

  // per-cycle comparison, away from the active edge
  logic mod_d = 1'b1;
  logic busy_d = 1'b0;
  always @(negedge clk) begin
    bit    e_busy;
    int    e_mod;
    string mtag;
    e_busy = (seg_len.size() != 0);
    e_mod  = e_busy ? seg_lvl[0] : 1;
    mtag   = !e_busy ? "R1" : (seg_bit[0] != 0 ? "R3" : "R4");
    chk(int'(mod_out) == e_mod, mtag, "mod_out", int'(mod_out), e_mod);
    chk(busy == e_busy, "R2", "busy", int'(busy), int'(e_busy));
    chk(in_ready == !e_busy, "R6", "in_ready", int'(in_ready), int'(!e_busy));
    chk(done == m_done, "R7", "done", int'(done), int'(m_done));
    if (rst_n && busy && busy_d && mod_d && !mod_out) begin
      chk(b_ticks == PER, "R5", "ticks per bit", b_ticks, PER);
      b_ticks = 0;
    end
    if (rst_n && done) begin
      chk(b_ticks == PER, "R5", "ticks in last bit", b_ticks, PER);
      b_ticks = 0;
    end
    mod_d  = mod_out;
    busy_d = busy;
  end

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic send_byte(input logic [DW-1:0] b, input bit junk);
    while (busy) @(negedge clk);
    in_valid = 1'b1;
    in_data  = b;
    @(negedge clk);
    chk(busy && !mod_out, "R2", "start of byte", int'({busy, mod_out}), 2);
    in_valid = 1'b0;
    in_data  = ~b;
    if (junk) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = 8'h00;
      repeat (2) @(negedge clk);
      in_valid = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(mod_out && !busy && !done && in_ready, "R1", "reset state",
        int'({mod_out, busy, done, in_ready}), 9);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    tick_mode = 0;
    send_byte(8'hA5, 1'b1);
    repeat (5) @(negedge clk);
    chk(!busy && mod_out, "R6", "no start from ignored request",
        int'({busy, mod_out}), 1);
    send_byte(8'h00, 1'b0);
    send_byte(8'hFF, 1'b0);

    tick_mode = 1;
    send_byte(8'h3C, 1'b1);
    tick_mode = 2;
    send_byte(8'h81, 1'b0);

    // R9: next byte offered in the done cycle
    in_valid = 1'b1;
    in_data  = 8'h6E;
    @(negedge clk);
    chk(busy == 1'b1, "R9", "back-to-back accept", int'(busy), 1);
    in_valid = 1'b0;
    while (!done) @(negedge clk);

    // R8: stall with no tick in the middle of a byte
    tick_mode = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h5A;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (7) @(negedge clk);
    tick_mode = 3;
    repeat (2) @(negedge clk);
    begin
      logic m0;
      m0 = mod_out;
      repeat (30) @(negedge clk);
      chk(mod_out == m0 && busy, "R8", "stall holds line",
          int'({busy, mod_out}), int'({1'b1, m0}));
    end
    tick_mode = 0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(mod_out && !busy, "R7", "idle high after byte", int'({busy, mod_out}), 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule